// File: doc/BRIEF.md
# Banked Intra-Subblock Permutation Memory

This block is the storage stage that follows the cross-lane shuffle in a parallel interleaver. It holds one bank memory per lane, each `DEPTH` words deep, so the whole bank holds one block of `LANES*DEPTH` soft metrics. During a write pass, one set of `LANES` metrics arrives on each valid beat. Each lane's metric goes into its own memory, at an address taken from a fixed per-lane address table. This scatters the metrics within each subblock in any order the table chooses.

Once a full pass has been stored, a read request walks every memory in step, from address 0 up to `DEPTH-1`. This delivers the metrics in natural order, one set per cycle, to the decoders that run the next half-iteration. Two address tables are held for each lane: one for the interleave pass and one for the deinterleave pass. A select input picks between them when each pass begins, so the same storage does both jobs. The table contents come from parameters: the address is `(beat*MUL + lane*OFF) mod DEPTH`, with an odd `MUL`, and `DEPTH` is a power of two.

Top module: `perm_bank`

## Requirements
- R1: After reset, `rd_valid_o` is low, and it stays low until a full write pass of `DEPTH` beats has been stored and a read has been requested.
- R2: With the select input at 0 on the first beat of a pass, the metric on lane i (bits `i*DW +: DW`) at write beat j (j counts accepted beats from 0) is stored at address `(j*MUL_A + i*OFF_A) mod DEPTH` of memory i.
- R3: With the select input at 1 on the first beat of a pass, the same metric is stored at address `(j*MUL_B + i*OFF_B) mod DEPTH` of memory i.
- R4: A read produces exactly `DEPTH` consecutive beats with `rd_valid_o` high. Beat k carries address k of every memory, lane i in bits `i*DW +: DW`. The first beat appears two cycles after the request is taken.
- R5: The select input is sampled only on the first beat of a pass; changing it on later beats of that pass has no effect.
- R6: A read request made before the current pass is complete is held, and the read starts after the last write beat of the pass.
- R7: While a complete pass waits to be read, write beats are ignored and the stored data is not altered.
- R8: A read request made while a read is running is ignored, and no second read follows.
- R9: Cycles with `wr_valid_i` low neither store data nor advance the beat count.
- R10: Once a read finishes, the next pass can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | A set of metrics is present on `wr_data_i` |
| wr_data_i | input | LANES*DW | One metric per lane, lane i in bits `i*DW +: DW` |
| tbl_sel_i | input | 1 | Table choice: 0 interleave, 1 deinterleave; sampled on the first beat of a pass |
| rd_start_i | input | 1 | Request to read back the stored pass |
| rd_valid_o | output | 1 | `rd_data_o` holds one address of every memory |
| rd_data_o | output | LANES*DW | One metric per lane, in natural address order |

## Verification
The hardest conditions to reach are those where requests arrive at awkward times. These are a read request that comes before the pass is complete, a second request that lands in the middle of a read, and a new pass that is driven while an unread pass is still held. The directed tasks create each of these on purpose. They pulse the start input before any write, and they insert idle gaps into the write stream. They fire a start on the third read beat. They also push a whole second pass with different data into a full bank. Each read is then checked beat by beat against the table mapping, and the bench confirms that no extra read beat follows.

// File: rtl/perm_pkg.sv
package perm_pkg;
  // Address a lane's metric lands on within its own memory.
  function automatic int unsigned perm_addr(input int unsigned lane,
                                            input int unsigned beat,
                                            input int unsigned mul,
                                            input int unsigned off,
                                            input int unsigned depth);
    return (beat * mul + lane * off) % depth;
  endfunction
endpackage

// File: rtl/perm_ctrl.sv
module perm_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid_i,
  input  logic          tbl_sel_i,
  input  logic          rd_start_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_beat_o,
  output logic          sel_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_valid_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_cnt, rd_cnt;
  logic          full, pending, rd_active, sel_q, go, rd_valid_q;

  assign wr_en_o   = wr_valid_i && !full;
  assign wr_beat_o = wr_cnt;
  assign sel_o     = (wr_cnt == '0) ? tbl_sel_i : sel_q;
  assign rd_en_o   = rd_active;
  assign rd_addr_o = rd_cnt;
  assign rd_valid_o = rd_valid_q;
  assign go = (pending || rd_start_i) && full && !rd_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt     <= '0;
      rd_cnt     <= '0;
      full       <= 1'b0;
      pending    <= 1'b0;
      rd_active  <= 1'b0;
      sel_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_active;
      if (wr_en_o) begin
        wr_cnt <= wr_cnt + 1'b1;
        if (wr_cnt == '0) sel_q <= tbl_sel_i;
        if (wr_cnt == LAST) full <= 1'b1;
      end
      if (go) pending <= 1'b0;
      else if (rd_start_i && !rd_active) pending <= 1'b1;
      if (go) rd_active <= 1'b1;
      else if (rd_active && rd_cnt == LAST) begin
        rd_active <= 1'b0;
        full      <= 1'b0;
      end
      if (rd_active) rd_cnt <= rd_cnt + 1'b1;
    end
  end

  // R1
  valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> $past(rd_active));
  // R6
  read_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    rd_active |-> full);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> wr_cnt == '0);
  // R8
  no_queued_start_chk: assert property (@(posedge clk) disable iff (rst)
    rd_active |-> !pending);
  // R4
  read_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_active && rd_cnt != LAST) |=> (rd_active && rd_cnt == $past(rd_cnt) + 1'b1));
  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_cnt != '0) |=> $stable(sel_q));
endmodule

// File: rtl/perm_lane.sv
module perm_lane #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int LANE  = 0,
  parameter int MUL_A = 3,
  parameter int OFF_A = 1,
  parameter int MUL_B = 5,
  parameter int OFF_B = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_beat_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0] tbl_a [DEPTH];
  logic [AW-1:0] tbl_b [DEPTH];
  logic [DW-1:0] mem   [DEPTH];
  logic [AW-1:0] wa;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl_a[g] = AW'(perm_pkg::perm_addr(LANE, g, MUL_A, OFF_A, DEPTH));
    assign tbl_b[g] = AW'(perm_pkg::perm_addr(LANE, g, MUL_B, OFF_B, DEPTH));
  end

  assign wa = sel_i ? tbl_b[wr_beat_i] : tbl_a[wr_beat_i];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wa] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/perm_bank.sv
module perm_bank #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int MUL_A = 3,
  parameter int OFF_A = 1,
  parameter int MUL_B = 5,
  parameter int OFF_B = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid_i,
  input  logic [LANES*DW-1:0] wr_data_i,
  input  logic                tbl_sel_i,
  input  logic                rd_start_i,
  output logic                rd_valid_o,
  output logic [LANES*DW-1:0] rd_data_o
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_en, sel, rd_en;
  logic [AW-1:0] wr_beat, rd_addr;

  perm_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst, .wr_valid_i, .tbl_sel_i, .rd_start_i,
    .wr_en_o(wr_en), .wr_beat_o(wr_beat), .sel_o(sel),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_valid_o
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    perm_lane #(
      .DW(DW), .DEPTH(DEPTH), .LANE(i),
      .MUL_A(MUL_A), .OFF_A(OFF_A), .MUL_B(MUL_B), .OFF_B(OFF_B)
    ) u_lane (
      .clk,
      .wr_en_i(wr_en), .wr_beat_i(wr_beat), .sel_i(sel),
      .wr_data_i(wr_data_i[i*DW +: DW]),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data_o[i*DW +: DW])
    );
  end
endmodule

// File: tb/test_perm_bank.sv
`timescale 1ns/1ps
module test_perm_bank;
  localparam int LANES = 4, DEPTH = 8, DW = 8;
  localparam int MUL_A = 3, OFF_A = 1, MUL_B = 5, OFF_B = 3;

  logic clk = 0, rst = 1, wr_valid = 0, tbl_sel = 0, rd_start = 0;
  logic [LANES*DW-1:0] wr_data = '0;
  logic rd_valid;
  logic [LANES*DW-1:0] rd_data;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  perm_bank i_perm_bank (
    .clk, .rst, .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .tbl_sel_i(tbl_sel), .rd_start_i(rd_start),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic logic [DW-1:0] val(int seed, int lane, int beat);
    return DW'(seed * 32 + lane * 8 + beat);
  endfunction

  function automatic logic [LANES*DW-1:0] expect_beat(int seed, logic s, int k);
    logic [LANES*DW-1:0] r = '0;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < DEPTH; j++) begin
        int a = s ? (j*MUL_B + i*OFF_B) % DEPTH : (j*MUL_A + i*OFF_A) % DEPTH;
        if (a == k) r[i*DW +: DW] = val(seed, i, j);
      end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [LANES*DW-1:0] act, logic [LANES*DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write one pass; gaps inserts idle cycles; flip toggles select after beat 0.
  task automatic write_pass(int seed, logic s, bit gaps, bit flip, bit watch_idle);
    for (int j = 0; j < DEPTH; j++) begin
      @(negedge clk);
      if (watch_idle) check(rd_valid == 0, "R6 no read during pass", {31'b0, rd_valid}, '0);
      wr_valid = 1;
      tbl_sel = (flip && j > 0) ? ~s : s;
      for (int i = 0; i < LANES; i++) wr_data[i*DW +: DW] = val(seed, i, j);
      if (gaps) begin
        @(negedge clk);
        wr_valid = 0;
        wr_data = '1;
        tbl_sel = ~s;
      end
    end
    @(negedge clk);
    wr_valid = 0;
  endtask

  // Read one pass and compare; mid_start fires a second request on beat 2.
  task automatic read_pass(int seed, logic s, bit pulse, bit mid_start, string req);
    int wait_c = 0;
    if (pulse) begin
      @(negedge clk); rd_start = 1;
      @(negedge clk); rd_start = 0;
    end
    while (!rd_valid && wait_c < 50) begin
      @(negedge clk); wait_c++;
    end
    for (int k = 0; k < DEPTH; k++) begin
      logic [LANES*DW-1:0] e = expect_beat(seed, s, k);
      check(rd_valid == 1, {req, " R4 valid"}, {31'b0, rd_valid}, 1);
      check(rd_data == e, req, rd_data, e);
      if (mid_start && k == 2) rd_start = 1;
      @(negedge clk);
      rd_start = 0;
    end
    check(rd_valid == 0, "R4 read length", {31'b0, rd_valid}, '0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    check(rd_valid == 0, "R1 reset", {31'b0, rd_valid}, '0);
    @(negedge clk); rd_start = 1; @(negedge clk); rd_start = 0;
    repeat (6) @(negedge clk);
    check(rd_valid == 0, "R1 start on empty bank", {31'b0, rd_valid}, '0);
    rst = 1; @(negedge clk); rst = 0;
  endtask

  task automatic t_interleave();
    write_pass(1, 1'b0, 0, 0, 0);
    read_pass(1, 1'b0, 1, 0, "R2 table A");
  endtask

  task automatic t_deinterleave();
    write_pass(2, 1'b1, 0, 0, 0);
    read_pass(2, 1'b1, 1, 0, "R3 table B R10");
  endtask

  task automatic t_sel_late();
    write_pass(3, 1'b0, 0, 1, 0);
    read_pass(3, 1'b0, 1, 0, "R5 late select ignored");
  endtask

  task automatic t_early_start();
    @(negedge clk); rd_start = 1; @(negedge clk); rd_start = 0;
    write_pass(4, 1'b1, 1, 0, 1);
    read_pass(4, 1'b1, 0, 0, "R6 R9 early start gaps");
  endtask

  task automatic t_full_ignore();
    write_pass(5, 1'b0, 0, 0, 0);
    write_pass(6, 1'b1, 0, 0, 0);
    read_pass(5, 1'b0, 1, 1, "R7 full bank kept");
    repeat (20) begin
      @(negedge clk);
      check(rd_valid == 0, "R8 no second read", {31'b0, rd_valid}, '0);
    end
  endtask

  initial begin
    t_reset();
    t_interleave();
    t_deinterleave();
    t_sel_late();
    t_early_start();
    t_full_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule